// File: doc/BRIEF.md
# Ping-Pong DMA Channel Sequencer

This block is the engine of one DMA channel. Each accepted peripheral request causes exactly one transfer between a fixed peripheral data address and a dual-port RAM. A transfer appears as one-cycle read and write strobes on a RAM port and on a peripheral port. A block is a run of transfers whose length comes from a 10-bit count register. When a block ends, the channel either re-arms on the same buffer, swaps to a second RAM buffer, or switches itself off. The choice depends on the operating mode.

Software sets up the channel while it is disabled. It writes a control word, a primary RAM start offset, a secondary RAM start offset, a peripheral address and the count, all in one write cycle. The same write sets the enable bit, and that starts the sequence. Bits 15:9 of the control word are ignored.

The state machine has four states:
- `ST_OFF`: the channel is idle.
- `ST_ARMED`: the channel waits for a request.
- `ST_MOVE`: one transfer is in progress and its strobes are high.
- `ST_WRAP`: the block is finished and the end-of-block decision is made.

It has these transitions:
- OFF→ARMED when the enable bit is set.
- ARMED→MOVE on a request.
- MOVE→ARMED after a transfer that is not the last one.
- MOVE→WRAP after the last transfer.
- WRAP→ARMED to continue or swap buffers.
- WRAP→OFF when a one-shot sequence ends.

Top module: `pingpong_dma_seq`

## Requirements
- R1: The channel comes out of reset disabled, with every strobe, `irq`, `chan_en` and `buf_sel` low. While the channel is disabled, requests are ignored and no strobe is raised.
- R2: Control word bit layout:
  - bit 0: enable.
  - bit 1: size.
  - bit 2: direction.
  - bit 3: half.
  - bit 4: null-write.
  - bits 6:5: address mode.
  - bits 8:7: operating mode.

  A configuration write is taken only while the channel is disabled. A write while enabled changes nothing.
- R3: Direction 1 raises `ram_rd` and `per_wr` in the transfer cycle. Direction 0 raises `per_rd` and `ram_wr`.
- R4: Size 1 marks byte transfers on `byte_xfer` and size 0 marks 16-bit words. In post-increment addressing (address mode 00), the RAM address advances by 1 per byte transfer and by 2 per word transfer, starting at the active buffer's start offset.
- R5: Address mode 01 holds the RAM address at the start offset for the whole block. Codes 10 and 11 behave as post-increment.
- R6: A block is count+1 transfers long. With half clear, `irq` pulses for one cycle, one cycle after the last transfer's strobe cycle.
- R7: With half set, `irq` pulses in the strobe cycle of transfer index count/2 (0-based, rounded down), and not at the block end.
- R8: With null-write set and direction 0, `per_wr` and `per_null` are raised alongside `ram_wr`. With direction 1, null-write has no effect.
- R9: Operating mode 00 (continuous) re-arms at the end of a block and restarts at the primary start offset with the full count.
- R10: Operating mode 01 (one-shot) clears the enable bit after one block, and further requests are ignored.
- R11: Operating mode 10 (continuous ping-pong) alternates blocks between the primary and the secondary buffer. `buf_sel` reads 0 while the primary buffer is active and 1 while the secondary buffer is active.
- R12: Operating mode 11 (one-shot ping-pong) moves one block to the primary buffer and one to the secondary buffer, then clears the enable bit.
- R13: A request sampled at a clock edge while the channel is armed raises the strobes in the following cycle. A request that arrives during a transfer or block-end cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ctrl | input | 16 | Control word |
| cfg_pri | input | AW | Primary RAM start offset |
| cfg_sec | input | AW | Secondary RAM start offset |
| cfg_paddr | input | AW | Peripheral data address |
| cfg_cnt | input | CW | Transfer count (block length minus one) |
| req | input | 1 | Peripheral transfer request |
| ram_addr | output | AW | RAM address of the current transfer |
| ram_rd | output | 1 | RAM read strobe |
| ram_wr | output | 1 | RAM write strobe |
| per_addr | output | AW | Peripheral address |
| per_rd | output | 1 | Peripheral read strobe |
| per_wr | output | 1 | Peripheral write strobe |
| per_null | output | 1 | Peripheral write carries null data |
| byte_xfer | output | 1 | Current unit is a byte |
| irq | output | 1 | Block-complete (or half-block) interrupt pulse |
| buf_sel | output | 1 | Active buffer: 0 primary, 1 secondary |
| chan_en | output | 1 | Channel enable status |

## Verification
The enable bit is visible one cycle after the configuration write. The sequencer arms one cycle after that. For this reason the bench leaves one idle cycle after every write before it raises a request.

Transfer strobes, the RAM address and the half-block interrupt are due in the cycle after the edge that samples the request. The end-of-block interrupt is due one cycle later still. The enable and buffer-select updates appear in the cycle after that.

The bench drives every input on the falling edge and samples each result on the falling edge of the cycle in which it is due. Between requests it leaves one spare cycle, so that no request lands in a block-end cycle except in the test that checks dropping.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_MOVE  = 2'd2,
        ST_WRAP  = 2'd3
    } seq_state_t;

    // control word, LSB first: en, size, dir, half, nullw, amode, mode
    typedef struct packed {
        logic [1:0] mode;
        logic [1:0] amode;
        logic       nullw;
        logic       half;
        logic       dir;
        logic       size;
        logic       en;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    localparam logic [1:0] AM_FIXED   = 2'b01;
    localparam logic [1:0] MD_ONESHOT = 2'b01;
    localparam logic [1:0] MD_PP_ONCE = 2'b11;

endpackage

// File: rtl/pp_dma_cfg.sv
module pp_dma_cfg
    import pp_dma_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [15:0]   cfg_ctrl,
    input  logic [AW-1:0] cfg_pri,
    input  logic [AW-1:0] cfg_sec,
    input  logic [AW-1:0] cfg_paddr,
    input  logic [CW-1:0] cfg_cnt,
    input  logic          clr_en,
    output ctrl_t         ctrl,
    output logic [AW-1:0] pri,
    output logic [AW-1:0] sec,
    output logic [AW-1:0] paddr,
    output logic [CW-1:0] cnt
);

    logic unused_ctrl_hi;
    assign unused_ctrl_hi = ^cfg_ctrl[15:CTRL_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl  <= '0;
            pri   <= '0;
            sec   <= '0;
            paddr <= '0;
            cnt   <= '0;
        end else if (cfg_we && !ctrl.en) begin
            ctrl  <= ctrl_t'(cfg_ctrl[CTRL_W-1:0]);
            pri   <= cfg_pri;
            sec   <= cfg_sec;
            paddr <= cfg_paddr;
            cnt   <= cfg_cnt;
        end else if (clr_en) begin
            ctrl.en <= 1'b0;
        end
    end

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.en && cfg_we && !clr_en) |=> ($stable(pri) && $stable(sec) && $stable(cnt))); // R2

endmodule

// File: rtl/pp_dma_seq.sv
module pp_dma_seq
    import pp_dma_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctrl_t         ctrl,
    input  logic [AW-1:0] pri,
    input  logic [AW-1:0] sec,
    input  logic [AW-1:0] paddr,
    input  logic [CW-1:0] cnt,
    input  logic          req,
    output logic [AW-1:0] ram_addr,
    output logic          ram_rd,
    output logic          ram_wr,
    output logic [AW-1:0] per_addr,
    output logic          per_rd,
    output logic          per_wr,
    output logic          per_null,
    output logic          byte_xfer,
    output logic          irq,
    output logic          buf_sel,
    output logic          clr_en
);

    seq_state_t    state, state_d;
    logic [CW-1:0] idx;
    logic [AW-1:0] addr;
    logic          buf_q;

    logic [AW-1:0] step;
    logic [CW-1:0] half_pt;
    logic          last;
    logic          stop;
    logic          pingpong;

    assign step     = (ctrl.amode == AM_FIXED) ? '0 :
                      (ctrl.size ? AW'(1) : AW'(2));
    assign half_pt  = cnt >> 1;
    assign last     = (idx == cnt);
    assign pingpong = ctrl.mode[1];
    assign stop     = (ctrl.mode == MD_ONESHOT) ||
                      ((ctrl.mode == MD_PP_ONCE) && buf_q);

    // next-state decision
    always_comb begin
        state_d = state;
        unique case (state)
            ST_OFF:   state_d = ctrl.en ? ST_ARMED : ST_OFF;
            ST_ARMED: state_d = req ? ST_MOVE : ST_ARMED;
            ST_MOVE:  state_d = last ? ST_WRAP : ST_ARMED;
            ST_WRAP:  state_d = stop ? ST_OFF : ST_ARMED;
            default:  state_d = ST_OFF;
        endcase
    end

    // state register and block datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;
            idx   <= '0;
            addr  <= '0;
            buf_q <= 1'b0;
        end else begin
            state <= state_d;
            unique case (state)
                ST_OFF: begin
                    if (ctrl.en) begin
                        idx   <= '0;
                        addr  <= pri;
                        buf_q <= 1'b0;
                    end
                end
                ST_MOVE: begin
                    if (!last) begin
                        idx  <= idx + CW'(1);
                        addr <= addr + step;
                    end
                end
                ST_WRAP: begin
                    idx <= '0;
                    if (!stop) begin
                        if (pingpong) begin
                            buf_q <= ~buf_q;
                            addr  <= buf_q ? pri : sec;
                        end else begin
                            addr  <= pri;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        ram_rd   = 1'b0;
        ram_wr   = 1'b0;
        per_rd   = 1'b0;
        per_wr   = 1'b0;
        per_null = 1'b0;
        irq      = 1'b0;
        clr_en   = 1'b0;
        unique case (state)
            ST_MOVE: begin
                if (ctrl.dir) begin
                    ram_rd = 1'b1;
                    per_wr = 1'b1;
                end else begin
                    per_rd   = 1'b1;
                    ram_wr   = 1'b1;
                    per_wr   = ctrl.nullw;
                    per_null = ctrl.nullw;
                end
                irq = ctrl.half && (idx == half_pt);
            end
            ST_WRAP: begin
                irq    = !ctrl.half;
                clr_en = stop;
            end
            default: ;
        endcase
    end

    assign ram_addr  = addr;
    assign per_addr  = paddr;
    assign byte_xfer = ctrl.size;
    assign buf_sel   = buf_q;

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.en |-> !(ram_rd || ram_wr || per_rd || per_wr)); // R1
    AST_DIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr |-> (!ram_rd && per_rd)); // R3
    AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MOVE && ctrl.amode == AM_FIXED && !last) |=> $stable(ram_addr)); // R5
    AST_IDX_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_OFF) |-> (idx <= cnt)); // R6
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R6
    AST_MOVE_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_rd || ram_wr) |-> $past(req)); // R13

endmodule

// File: rtl/pingpong_dma_seq.sv
module pingpong_dma_seq
    import pp_dma_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [15:0]   cfg_ctrl,
    input  logic [AW-1:0] cfg_pri,
    input  logic [AW-1:0] cfg_sec,
    input  logic [AW-1:0] cfg_paddr,
    input  logic [CW-1:0] cfg_cnt,
    input  logic          req,
    output logic [AW-1:0] ram_addr,
    output logic          ram_rd,
    output logic          ram_wr,
    output logic [AW-1:0] per_addr,
    output logic          per_rd,
    output logic          per_wr,
    output logic          per_null,
    output logic          byte_xfer,
    output logic          irq,
    output logic          buf_sel,
    output logic          chan_en
);

    ctrl_t         ctrl;
    logic [AW-1:0] pri, sec, paddr;
    logic [CW-1:0] cnt;
    logic          clr_en;

    pp_dma_cfg #(.AW(AW), .CW(CW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_ctrl  (cfg_ctrl),
        .cfg_pri   (cfg_pri),
        .cfg_sec   (cfg_sec),
        .cfg_paddr (cfg_paddr),
        .cfg_cnt   (cfg_cnt),
        .clr_en    (clr_en),
        .ctrl      (ctrl),
        .pri       (pri),
        .sec       (sec),
        .paddr     (paddr),
        .cnt       (cnt)
    );

    pp_dma_seq #(.AW(AW), .CW(CW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl),
        .pri       (pri),
        .sec       (sec),
        .paddr     (paddr),
        .cnt       (cnt),
        .req       (req),
        .ram_addr  (ram_addr),
        .ram_rd    (ram_rd),
        .ram_wr    (ram_wr),
        .per_addr  (per_addr),
        .per_rd    (per_rd),
        .per_wr    (per_wr),
        .per_null  (per_null),
        .byte_xfer (byte_xfer),
        .irq       (irq),
        .buf_sel   (buf_sel),
        .clr_en    (clr_en)
    );

    assign chan_en = ctrl.en;

endmodule

// File: tb/tb_pingpong_dma_seq.sv
module tb_pingpong_dma_seq;

    localparam int AW = 16;
    localparam int CW = 10;
    localparam int NV = 6;

    // each entry: {control[15:0], primary offset[15:0], count[9:0]}
    localparam logic [41:0] VEC [NV] = '{
        {16'h0001, 16'h0100, 10'd3},  // word, periph->RAM, post-inc, continuous
        {16'h0087, 16'h0200, 10'd2},  // byte, RAM->periph, one-shot
        {16'h00B1, 16'h0300, 10'd2},  // word, fixed address, null-write, one-shot
        {16'h004B, 16'h0040, 10'd4},  // byte, code 10, half irq, continuous
        {16'h00F5, 16'h0500, 10'd0},  // word, RAM->periph, null ignored, code 11
        {16'h0089, 16'h0600, 10'd3}   // word, half irq, one-shot
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [15:0]   cfg_ctrl = '0;
    logic [AW-1:0] cfg_pri = '0, cfg_sec = '0, cfg_paddr = '0;
    logic [CW-1:0] cfg_cnt = '0;
    logic          req = 1'b0;
    logic [AW-1:0] ram_addr, per_addr;
    logic          ram_rd, ram_wr, per_rd, per_wr, per_null, byte_xfer, irq, buf_sel, chan_en;

    int checks = 0;
    int errors = 0;

    logic [AW-1:0] s_addr;
    logic          s_rrd, s_rwr, s_prd, s_pwr, s_null, s_byte, s_irq_m, s_irq_w;

    logic [15:0] c;
    logic [15:0] p;
    logic [9:0]  n;
    int          step;

    always #4 clk = ~clk;

    pingpong_dma_seq #(.AW(AW), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ctrl(cfg_ctrl),
        .cfg_pri(cfg_pri), .cfg_sec(cfg_sec), .cfg_paddr(cfg_paddr), .cfg_cnt(cfg_cnt),
        .req(req), .ram_addr(ram_addr), .ram_rd(ram_rd), .ram_wr(ram_wr),
        .per_addr(per_addr), .per_rd(per_rd), .per_wr(per_wr), .per_null(per_null),
        .byte_xfer(byte_xfer), .irq(irq), .buf_sel(buf_sel), .chan_en(chan_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic do_cfg(input logic [15:0] cw, input logic [15:0] a, input logic [15:0] b,
                          input logic [9:0] k);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ctrl = cw; cfg_pri = a; cfg_sec = b; cfg_cnt = k; cfg_paddr = 16'hF00D;
        @(negedge clk) cfg_we = 1'b0;
        @(negedge clk);
    endtask

    // one request; samples the strobe cycle and the cycle after
    task automatic do_xfer();
        @(negedge clk) req = 1'b1;
        @(negedge clk) req = 1'b0;
        s_addr = ram_addr; s_rrd = ram_rd; s_rwr = ram_wr; s_prd = per_rd;
        s_pwr = per_wr; s_null = per_null; s_byte = byte_xfer; s_irq_m = irq;
        @(negedge clk) s_irq_w = irq;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        chk("R1 reset strobes", {ram_rd, ram_wr, per_rd, per_wr, per_null}, 0);
        chk("R1 reset status", {irq, chan_en, buf_sel}, 0);
        // R1: requests while disabled
        do_xfer();
        chk("R1 request while disabled", {s_rrd, s_rwr, s_prd, s_pwr, s_irq_m, s_irq_w}, 0);

        // vector table walk
        for (int v = 0; v < NV; v++) begin
            c = VEC[v][41:26]; p = VEC[v][25:10]; n = VEC[v][9:0];
            step = (c[6:5] == 2'b01) ? 0 : (c[1] ? 1 : 2);
            do_reset();
            do_cfg(c, p, 16'h7000, n);
            chk("R2 enable after write", chan_en, 1);
            for (int i = 0; i <= int'(n); i++) begin
                do_xfer();
                chk("R4/R5 address", s_addr, p + i * step);
                chk("R4 byte flag", s_byte, c[1]);
                chk("R3 ram_rd", s_rrd, c[2]);
                chk("R3 ram_wr", s_rwr, !c[2]);
                chk("R3 per_rd", s_prd, !c[2]);
                chk("R8 per_wr", s_pwr, c[2] | c[4]);
                chk("R8 per_null", s_null, !c[2] & c[4]);
                chk("R7 half irq", s_irq_m, c[3] && (i == int'(n >> 1)));
                chk("R6 end irq", s_irq_w, !c[3] && (i == int'(n)));
            end
            @(negedge clk);
            if (c[8:7] == 2'b01) begin
                chk("R10 one-shot clears enable", chan_en, 0);
                do_xfer();
                chk("R10 request after one-shot", {s_rrd, s_rwr, s_prd, s_pwr}, 0);
            end else begin
                chk("R9 continuous keeps enable", chan_en, 1);
                do_xfer();
                chk("R9 restart at primary", s_addr, p);
            end
        end

        // R2: write while enabled has no effect; R13: dropped request
        do_reset();
        do_cfg(16'h0001, 16'h0100, 16'h0000, 10'd3);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ctrl = 16'h0007; cfg_pri = 16'h0900; cfg_cnt = 10'd0;
        @(negedge clk) cfg_we = 1'b0;
        do_xfer();
        chk("R2 locked write address", s_addr, 16'h0100);
        chk("R2 locked write direction", s_rwr, 1);
        @(negedge clk) req = 1'b1;
        @(negedge clk);
        chk("R13 strobe after request", ram_wr, 1);
        chk("R13 address second", ram_addr, 16'h0102);
        @(negedge clk) req = 1'b0;
        chk("R13 request in transfer dropped", {ram_rd, ram_wr, per_rd, per_wr}, 0);
        do_xfer();
        chk("R13 next address", s_addr, 16'h0104);

        // R11: continuous ping-pong
        do_reset();
        do_cfg(16'h0101, 16'h1000, 16'h2000, 10'd1);
        do_xfer(); chk("R11 pri first", s_addr, 16'h1000);
        chk("R11 buf primary", buf_sel, 0);
        do_xfer(); chk("R11 pri second", s_addr, 16'h1002);
        chk("R6 ping-pong end irq", s_irq_w, 1);
        @(negedge clk);
        chk("R11 buf secondary", buf_sel, 1);
        do_xfer(); chk("R11 sec first", s_addr, 16'h2000);
        do_xfer(); chk("R11 sec second", s_addr, 16'h2002);
        @(negedge clk);
        chk("R11 buf back to primary", buf_sel, 0);
        do_xfer(); chk("R11 pri again", s_addr, 16'h1000);

        // R12: one-shot ping-pong
        do_reset();
        do_cfg(16'h0181, 16'h3000, 16'h4000, 10'd0);
        do_xfer(); chk("R12 primary block", s_addr, 16'h3000);
        @(negedge clk);
        chk("R12 enable after first", chan_en, 1);
        chk("R12 buf after first", buf_sel, 1);
        do_xfer(); chk("R12 secondary block", s_addr, 16'h4000);
        @(negedge clk);
        chk("R12 enable cleared", chan_en, 0);
        do_xfer();
        chk("R12 request after stop", {s_rrd, s_rwr, s_prd, s_pwr}, 0);

        summary();
        $finish;
    end

endmodule